// File: doc/BRIEF.md
# Priority Packet Transmit Arbiter

This block lets two producers share one outgoing 16-bit word stream. One producer is a bulk data FIFO and the other is a slow-control FIFO. The block reads both FIFOs through first-word-fall-through read ports: the head word is visible while empty is low, and a pop removes that word at the next clock edge. The output is a word with a valid/ready handshake. Whenever no packet is in flight, the block picks a source by a priority rule that depends on the fill flags of the two FIFOs. The data FIFO wins outright when it is nearly full. Otherwise a waiting control message goes before ordinary data, so control traffic is never held back by a steady data flow.

Each packet is sent as one word per accepted beat in this order: a start marker that names the class, the payload, a CRC-16 word computed over the payload, and a shared end marker. A data packet drains the data FIFO until 64 words have been sent or the FIFO runs dry. A control packet always carries a single word. Once a packet has started, the choice of source cannot change until that packet's end marker has been accepted.

Top module: `pta_tx_arbiter`

## Requirements
- R1: While rst_n is low, tx_valid, dat_pop and ctl_pop are all low. The first cycle after reset finds the block idle.
- R2: While idle with both FIFOs empty, tx_valid stays low and no marker is produced.
- R3: If the block is idle and the data FIFO is non-empty with dat_afull high, the next packet is a data packet, even when the control FIFO also holds a word.
- R4: If the block is idle and dat_afull is low, a non-empty control FIFO is served before a non-empty data FIFO.
- R5: A data packet opens with the word 0x951C and a control packet opens with the word 0x95FB. The marker is presented in the cycle after the source is chosen.
- R6: Every packet closes with the word 0x95FD, which directly follows the CRC word.
- R7: The CRC word is CRC-16 with polynomial 0x1021 and seed 0xFFFF. It is computed MSB first over the accepted payload words, with no final inversion.
- R8: A data packet carries at most 64 payload words. It ends early, moving to its CRC word, in any payload cycle that finds the data FIFO empty. No word is presented in that cycle.
- R9: A control packet carries exactly one payload word: the control FIFO's head.
- R10: Arbitration happens only between packets. A word arriving in the other FIFO during a packet does not alter that packet.
- R11: While tx_valid is high and tx_ready is low, tx_word holds steady. A FIFO is popped only in the cycle its payload word is accepted.
- R12: dat_pop and ctl_pop are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_word | input | 16 | Head word of the data FIFO |
| dat_empty | input | 1 | Data FIFO empty |
| dat_afull | input | 1 | Data FIFO almost full |
| dat_pop | output | 1 | Pops the data FIFO head |
| ctl_word | input | 16 | Head word of the control FIFO |
| ctl_empty | input | 1 | Control FIFO empty |
| ctl_pop | output | 1 | Pops the control FIFO head |
| tx_word | output | 16 | Outgoing word |
| tx_valid | output | 1 | tx_word is valid |
| tx_ready | input | 1 | Sink accepts tx_word this cycle |

## Verification
A stuck or wrong packet phase shows up in the very next presented word. That word is a marker, a payload word or a CRC where a different one was due, and the bench flags it in the same cycle. A wrong payload counter shows up as a data packet that stops short of, or runs past, its 64-word limit, at the boundary beat. A corrupted CRC register stays hidden until the CRC beat, and then every later bit of the error shows up in that single word. A wrong priority decision shows up one cycle after an idle cycle, as the wrong start marker.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] MARK_DATA = 16'h951C;
  localparam logic [WORD_W-1:0] MARK_CTRL = 16'h95FB;
  localparam logic [WORD_W-1:0] MARK_END  = 16'h95FD;
  localparam logic [WORD_W-1:0] CRC_POLY  = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED  = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOP, ST_PAY, ST_CRC, ST_EOP
  } pta_state_e;

  typedef enum logic {
    CLS_DATA = 1'b0,
    CLS_CTRL = 1'b1
  } pta_class_e;

  // One full word folded into the CRC, most significant bit first.
  function automatic logic [WORD_W-1:0] crc_fold(
    input logic [WORD_W-1:0] crc_in,
    input logic [WORD_W-1:0] word
  );
    logic [WORD_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ word[i];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/pta_pick.sv
module pta_pick
  import pta_pkg::*;
(
  input  logic       dat_empty,
  input  logic       dat_afull,
  input  logic       ctl_empty,
  output logic       pick_any,
  output pta_class_e pick_cls
);
  logic dat_urgent;
  assign dat_urgent = !dat_empty && dat_afull;

  always_comb begin
    pick_any = 1'b1;
    if (dat_urgent)      pick_cls = CLS_DATA;
    else if (!ctl_empty) pick_cls = CLS_CTRL;
    else if (!dat_empty) pick_cls = CLS_DATA;
    else begin
      pick_any = 1'b0;
      pick_cls = CLS_DATA;
    end
  end
endmodule

// File: rtl/pta_crc.sv
module pta_crc
  import pta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)       crc <= CRC_SEED;
    else if (clear)   crc <= CRC_SEED;
    else if (advance) crc <= crc_fold(crc, word);
  end
endmodule

// File: rtl/pta_tx_arbiter.sv
module pta_tx_arbiter
  import pta_pkg::*;
#(
  parameter int MAX_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] dat_word,
  input  logic        dat_empty,
  input  logic        dat_afull,
  output logic        dat_pop,
  input  logic [15:0] ctl_word,
  input  logic        ctl_empty,
  output logic        ctl_pop,
  output logic [15:0] tx_word,
  output logic        tx_valid,
  input  logic        tx_ready
);
  localparam int CW = $clog2(MAX_WORDS + 1);

  pta_state_e state_q, state_d;
  pta_class_e cls_q, pick_cls;
  logic [CW-1:0] cnt_q;
  logic [WORD_W-1:0] crc_val;
  logic pick_any;

  // named events
  logic accept, pay_take, pay_last, pay_dry, sop_take;

  pta_pick u_pick (
    .dat_empty(dat_empty),
    .dat_afull(dat_afull),
    .ctl_empty(ctl_empty),
    .pick_any (pick_any),
    .pick_cls (pick_cls)
  );

  pta_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (sop_take),
    .advance(pay_take),
    .word   (tx_word),
    .crc    (crc_val)
  );

  always_comb begin
    tx_valid = 1'b0;
    tx_word  = '0;
    unique case (state_q)
      ST_SOP: begin
        tx_valid = 1'b1;
        tx_word  = (cls_q == CLS_CTRL) ? MARK_CTRL : MARK_DATA;
      end
      ST_PAY: begin
        if (cls_q == CLS_CTRL) begin
          tx_valid = !ctl_empty;
          tx_word  = ctl_word;
        end else begin
          tx_valid = !dat_empty;
          tx_word  = dat_word;
        end
      end
      ST_CRC: begin
        tx_valid = 1'b1;
        tx_word  = crc_val;
      end
      ST_EOP: begin
        tx_valid = 1'b1;
        tx_word  = MARK_END;
      end
      default: ;
    endcase
  end

  assign accept   = tx_valid && tx_ready;
  assign sop_take = (state_q == ST_SOP) && accept;
  assign pay_take = (state_q == ST_PAY) && accept;
  assign pay_last = (cls_q == CLS_CTRL) || (cnt_q == CW'(MAX_WORDS - 1));
  assign pay_dry  = (state_q == ST_PAY) && (cls_q == CLS_DATA) && dat_empty;
  assign dat_pop  = pay_take && (cls_q == CLS_DATA);
  assign ctl_pop  = pay_take && (cls_q == CLS_CTRL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pick_any) state_d = ST_SOP;
      ST_SOP:  if (accept) state_d = ST_PAY;
      ST_PAY: begin
        if (pay_dry) state_d = ST_CRC;
        else if (pay_take && pay_last) state_d = ST_CRC;
      end
      ST_CRC:  if (accept) state_d = ST_EOP;
      ST_EOP:  if (accept) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cls_q   <= CLS_DATA;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && pick_any) cls_q <= pick_cls;
      if (sop_take) cnt_q <= '0;
      else if (pay_take) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R12
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_pop && ctl_pop));

  // R11
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_word)));

  // R8
  pay_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_WORDS));

  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && dat_empty && ctl_empty) |=> !tx_valid);

  // R3
  urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !dat_empty && dat_afull) |=> (tx_valid && tx_word == MARK_DATA));

  // R10
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(cls_q));

  // R9
  ctl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pop |=> (state_q == ST_CRC));
endmodule

// File: tb/tb_pta_tx_arbiter.sv
`timescale 1ns/1ps
module tb_pta_tx_arbiter;
  localparam int MAXW = 64;
  localparam int AF = 12;
  localparam int RUN = 820;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] dat_word = '0, ctl_word = '0;
  logic dat_empty = 1'b1, dat_afull = 1'b0, ctl_empty = 1'b1, tx_ready = 1'b1;
  logic dat_pop, ctl_pop, tx_valid;
  logic [15:0] tx_word;

  always #4 clk = ~clk;

  pta_tx_arbiter #(.MAX_WORDS(MAXW)) dut (
    .clk(clk), .rst_n(rst_n),
    .dat_word(dat_word), .dat_empty(dat_empty), .dat_afull(dat_afull), .dat_pop(dat_pop),
    .ctl_word(ctl_word), .ctl_empty(ctl_empty), .ctl_pop(ctl_pop),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int dq[$];
  int cq[$];

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int crc_step(input int c, input int w);
    int r = c;
    for (int k = 15; k >= 0; k--) begin
      int fb = ((r >> 15) ^ (w >> k)) & 1;
      r = (r << 1) & 16'hFFFF;
      if (fb != 0) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic drive_fifos();
    dat_empty = (dq.size() == 0);
    dat_afull = (dq.size() >= AF);
    dat_word  = (dq.size() != 0) ? 16'(dq[0]) : 16'h0;
    ctl_empty = (cq.size() == 0);
    ctl_word  = (cq.size() != 0) ? 16'(cq[0]) : 16'h0;
  endtask

  // model: phase 0 idle, 1 start, 2 payload, 3 crc, 4 end; ctl=1 control packet
  int phase = 0, ctl = 0, cnt = 0, crc = 16'hFFFF;
  string pick_tag = "R5";
  int lfsr = 16'hACE1;
  bit prev_stall = 0;
  logic [15:0] prev_word = '0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(tx_valid == 0, "R1", "tx_valid in reset", tx_valid, 0);
      check(dat_pop == 0 && ctl_pop == 0, "R1", "pop in reset", {dat_pop, ctl_pop}, 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    for (int cyc = 0; cyc < RUN; cyc++) begin
      bit ev; int ew; bit edp; bit ecp; string tag; bit adp; bit acp;
      @(negedge clk);
      ev = 0; ew = 0; edp = 0; ecp = 0; tag = "R2";
      case (phase)
        1: begin ev = 1; ew = ctl ? 16'h95FB : 16'h951C; tag = pick_tag; end
        2: begin
          if (ctl != 0) begin
            ev = 1; ew = cq[0]; ecp = tx_ready; tag = "R9";
          end else begin
            tag = (cq.size() != 0) ? "R10" : "R8";
            if (dq.size() != 0) begin ev = 1; ew = dq[0]; edp = tx_ready; end
          end
        end
        3: begin ev = 1; ew = crc; tag = "R7"; end
        4: begin ev = 1; ew = 16'h95FD; tag = "R6"; end
        default: ;
      endcase
      check(tx_valid == ev, tag, "tx_valid", tx_valid, ev);
      if (ev) check(tx_word == 16'(ew), tag, "tx_word", tx_word, ew);
      check(dat_pop == edp && ctl_pop == ecp, "R11", "pops", {dat_pop, ctl_pop}, {edp, ecp});
      check(!(dat_pop && ctl_pop), "R12", "double pop", {dat_pop, ctl_pop}, 0);
      if (prev_stall) check(tx_valid && tx_word == prev_word, "R11", "held word", tx_word, prev_word);
      prev_stall = tx_valid && !tx_ready;
      prev_word = tx_word;

      case (phase)
        0: begin
          if (dq.size() != 0 && dat_afull) begin ctl = 0; phase = 1; pick_tag = (cq.size() != 0) ? "R3" : "R5"; end
          else if (cq.size() != 0) begin ctl = 1; phase = 1; pick_tag = (dq.size() != 0) ? "R4" : "R5"; end
          else if (dq.size() != 0) begin ctl = 0; phase = 1; pick_tag = "R5"; end
        end
        1: if (tx_ready) begin phase = 2; cnt = 0; crc = 16'hFFFF; end
        2: begin
          if (ctl != 0) begin
            if (tx_ready) begin crc = crc_step(crc, cq[0]); phase = 3; end
          end else if (dq.size() == 0) phase = 3;
          else if (tx_ready) begin
            crc = crc_step(crc, dq[0]); cnt++;
            if (cnt == MAXW) phase = 3;
          end
        end
        3: if (tx_ready) phase = 4;
        4: if (tx_ready) phase = 0;
        default: phase = 0;
      endcase
      adp = dat_pop; acp = ctl_pop;

      @(posedge clk); #1;
      if (adp && dq.size() != 0) void'(dq.pop_front());
      if (acp && cq.size() != 0) void'(cq.pop_front());
      tx_ready = 1'b1;
      if (cyc == 10) for (int i = 0; i < 3; i++) dq.push_back(16'h1000 + i);
      if (cyc == 40) begin
        for (int i = 0; i < 2; i++) cq.push_back(16'hC000 + i);
        for (int i = 0; i < 4; i++) dq.push_back(16'h2000 + i);
      end
      if (cyc == 100) begin
        for (int i = 0; i < 20; i++) dq.push_back(16'h3000 + i);
        cq.push_back(16'hC100);
      end
      if (cyc == 200) for (int i = 0; i < 70; i++) dq.push_back(16'h4000 + i);
      if (cyc == 210) cq.push_back(16'hC200);
      if (cyc >= 400 && cyc < 760) begin
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
        tx_ready = (lfsr & 16'h0009) != 0;
        if (cyc % 37 == 0) begin
          for (int i = 0; i < (lfsr % 15) + 1; i++) dq.push_back((lfsr ^ (i * 16'h0101)) & 16'hFFFF);
          if ((lfsr & 16'h0040) != 0) cq.push_back(lfsr ^ 16'h5A5A);
        end
      end
      drive_fifos();
    end

    check(dq.size() == 0 && cq.size() == 0, "R8", "drained", dq.size() + cq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule